// File: doc/BRIEF.md
# Dual-Edge Cascaded Column Data Loader

This block collects 8-bit grey levels for a row of display columns. A free-running system clock samples a slow shift clock. Every transition of the shift clock, rising or falling, stores the byte present on the parallel data bus into the next channel register. The first byte goes to channel 0, the next to channel 1, and so on. Loading is enabled only while the select input is high. Once every channel holds a byte, the select output goes high, so a second loader wired behind this one takes the remaining bytes of the same stream.

The channel registers are not seen by the pulse-width stage directly. A one-cycle load pulse copies the whole bank into a shadow set at once, and the shadow set drives the outputs. The next row can therefore be shifted in while the current row is still being displayed.

The data port has no valid/ready handshake and no back-pressure. A byte is taken when a shift-clock transition is seen, so the sender must hold each byte stable until the capture has happened.

Top module: `col_loader`

## Requirements
- R1: After reset, `sel_out` is low and every shadow byte reads 0.
- R2: While `sel_in` is high, each shift-clock transition of either polarity stores `data_in` (bit 7 most significant) in the next free channel. Channel k appears at `shadow_out[8k+7:8k]` after the next load, and the first byte after selection goes to channel 0.
- R3: Shift-clock transitions seen while `sel_in` is low store nothing, and no channel changes.
- R4: Holding `sel_in` low for at least one cycle returns the fill position to channel 0. Channels that are not rewritten keep their earlier bytes.
- R5: After the last channel is stored, `sel_out` goes high and stays high while `sel_in` stays high. Further transitions store nothing.
- R6: `sel_out` is low in any cycle in which `sel_in` is low.
- R7: `shadow_out` changes only at a clock edge where `load_pulse` is high. That edge copies all channel registers at once.
- R8: When a load and a capture fall on the same edge, the shadow receives the bank as it was before that capture. The captured byte appears at the following load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_clk_in | input | 1 | Asynchronous shift clock; both transitions capture a byte |
| sel_in | input | 1 | Select input; high enables loading |
| data_in | input | 8 | Grey-level byte, bit 7 most significant |
| load_pulse | input | 1 | One-cycle pulse that copies the bank into the shadow set |
| sel_out | output | 1 | Select output to the next loader in the chain |
| shadow_out | output | 256 | Shadow copy of all channels, channel k in bits [8k+7:8k] |

## Verification
A capture and a load can fall on the same clock edge. In that case the shadow copy must take the bank as it stood before the write. The bench provokes this by toggling the shift clock and raising `load_pulse` exactly at the third edge after the toggle. That edge is the one where the synchronized transition commits the byte. The bench then checks that the shadow shows the old channel value, and that a second load shows the new one.

// File: rtl/col_loader_pkg.sv
package col_loader_pkg;
  localparam int CL_NUM_CH      = 32;
  localparam int CL_DATA_W      = 8;
  localparam int CL_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    FILL_IDLE   = 2'd0,
    FILL_ACTIVE = 2'd1,
    FILL_FULL   = 2'd2
  } fill_state_e;
endpackage

// File: rtl/col_edge_sync.sv
module col_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_strobe
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // any change of the synchronized level, either direction
  assign edge_strobe = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/col_fill_ctrl.sv
module col_fill_ctrl
  import col_loader_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_in,
  input  logic             strobe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

  fill_state_e      state_q;
  logic [PTR_W-1:0] ptr_q;

  assign wr_en  = strobe && sel_in && (state_q != FILL_FULL);
  assign wr_ptr = ptr_q;
  assign full   = (state_q == FILL_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n || !sel_in) begin
      state_q <= FILL_IDLE;
      ptr_q   <= '0;
    end else if (wr_en) begin
      if (ptr_q == LAST) begin
        state_q <= FILL_FULL;
      end else begin
        state_q <= FILL_ACTIVE;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/col_chan_bank.sv
module col_chan_bank #(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         wr_ptr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     load,
  output logic [NUM_CH*DATA_W-1:0] shadow
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] ch_q;
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_q <= '0;
        sh_q <= '0;
      end else begin
        if (wr_en && (wr_ptr == PTR_W'(g))) ch_q <= wr_data;
        if (load) sh_q <= ch_q;
      end
    end

    assign shadow[g*DATA_W +: DATA_W] = sh_q;
  end
endmodule

// File: rtl/col_loader.sv
module col_loader
  import col_loader_pkg::*;
#(
  parameter int NUM_CH      = CL_NUM_CH,
  parameter int DATA_W      = CL_DATA_W,
  parameter int SYNC_STAGES = CL_SYNC_STAGES,
  localparam int PTR_W      = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_clk_in,
  input  logic                     sel_in,
  input  logic [DATA_W-1:0]        data_in,
  input  logic                     load_pulse,
  output logic                     sel_out,
  output logic [NUM_CH*DATA_W-1:0] shadow_out
);
  logic             strobe;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr;
  logic             full;

  col_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(shift_clk_in), .edge_strobe(strobe)
  );

  col_fill_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .strobe(strobe),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .full(full)
  );

  col_chan_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(data_in), .load(load_pulse), .shadow(shadow_out)
  );

  // released at once when this device is deselected
  assign sel_out = full && sel_in;
endmodule

// File: rtl/col_loader_chk.sv
module col_loader_chk #(
  parameter int NUM_CH = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(NUM_CH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sel_in,
  input logic                     sel_out,
  input logic                     load_pulse,
  input logic [NUM_CH*DATA_W-1:0] shadow_out,
  input logic                     wr_en,
  input logic [PTR_W-1:0]         wr_ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(shadow_out));

  assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_out && sel_in) |=> (sel_out || !sel_in));

  assert_full_at_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_out |-> (wr_ptr == LAST));

  assert_ptr_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |=> (wr_ptr == '0));

  assert_no_write_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |-> !wr_en);

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + 1'b1));
endmodule

bind col_loader col_loader_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sel_out(sel_out),
  .load_pulse(load_pulse), .shadow_out(shadow_out),
  .wr_en(wr_en), .wr_ptr(wr_ptr)
);

// File: tb/col_loader_tb.sv
`timescale 1ns/1ps
module col_loader_tb_top;
  localparam int NCH = 32;

  // pattern table: {seed, step}; channel k expects seed + k*step
  localparam int NPAT = 4;
  localparam logic [15:0] PAT [NPAT] = '{16'h00_01, 16'h80_07, 16'hFF_FF, 16'h3C_25};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk_in = 1'b0;
  logic sel_in = 1'b0;
  logic [7:0] data_in = '0;
  logic load_pulse = 1'b0;
  logic sel_out;
  logic [NCH*8-1:0] shadow_out;

  int checks = 0;
  int fails = 0;
  int cnt = 0;
  logic [7:0] exp_reg [NCH];
  logic [7:0] exp_sh  [NCH];

  always #2 clk = ~clk;

  col_loader dut_i (
    .clk(clk), .rst_n(rst_n), .shift_clk_in(shift_clk_in), .sel_in(sel_in),
    .data_in(data_in), .load_pulse(load_pulse), .sel_out(sel_out),
    .shadow_out(shadow_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] b);
    if (sel_in && cnt < NCH) begin
      exp_reg[cnt] = b;
      cnt++;
    end
  endtask

  task automatic shift_byte(input logic [7:0] b);
    @(negedge clk);
    data_in = b;
    shift_clk_in = ~shift_clk_in;
    model_write(b);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_pulse = 1'b1;
    @(negedge clk);
    load_pulse = 1'b0;
    for (int k = 0; k < NCH; k++) exp_sh[k] = exp_reg[k];
  endtask

  task automatic set_sel(input logic v);
    @(negedge clk);
    sel_in = v;
    if (!v) cnt = 0;
    #1;
    if (!v) chk("R6 sel_out low while deselected", 32'(sel_out), 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_shadow(input string req);
    #1;
    for (int k = 0; k < NCH; k++)
      chk(req, 32'(shadow_out[k*8 +: 8]), 32'(exp_sh[k]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < NCH; k++) begin exp_reg[k] = 8'h00; exp_sh[k] = 8'h00; end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 sel_out at reset", 32'(sel_out), 32'd0);
    check_shadow("R1 shadow zero at reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 fill order, R5 full, R7 hold, R4 restart between rows
    for (int p = 0; p < NPAT; p++) begin
      set_sel(1'b1);
      for (int k = 0; k < NCH; k++)
        shift_byte(8'(PAT[p][15:8] + 8'(k) * PAT[p][7:0]));
      chk("R5 sel_out after last channel", 32'(sel_out), 32'd1);
      check_shadow("R7 shadow unchanged before load");
      do_load();
      check_shadow("R2 channel order and bytes");
      set_sel(1'b0);
    end

    // R3: transitions while deselected store nothing
    shift_byte(8'hEE);
    shift_byte(8'hEE);
    shift_byte(8'hEE);
    do_load();
    check_shadow("R3 deselected transitions ignored");

    // R5: extra transitions after full are ignored
    set_sel(1'b1);
    for (int k = 0; k < NCH; k++) shift_byte(8'(8'h10 + k));
    shift_byte(8'hAB);
    shift_byte(8'hCD);
    chk("R5 sel_out stays high", 32'(sel_out), 32'd1);
    do_load();
    check_shadow("R5 no overwrite after full");
    set_sel(1'b0);

    // R4: partial fill, deselect, refill restarts at channel 0
    set_sel(1'b1);
    for (int k = 0; k < 5; k++) shift_byte(8'(8'hA0 + k));
    chk("R5 sel_out low on partial fill", 32'(sel_out), 32'd0);
    set_sel(1'b0);
    set_sel(1'b1);
    shift_byte(8'h5A);
    shift_byte(8'h81);
    do_load();
    check_shadow("R4 pointer restart keeps other channels");
    set_sel(1'b0);

    // R8: load on the same edge as a capture
    set_sel(1'b1);
    @(negedge clk);
    data_in = 8'h77;
    shift_clk_in = ~shift_clk_in;
    repeat (2) @(negedge clk);
    load_pulse = 1'b1;
    for (int k = 0; k < NCH; k++) exp_sh[k] = exp_reg[k];
    model_write(8'h77);
    @(negedge clk);
    load_pulse = 1'b0;
    check_shadow("R8 coincident load takes old bank");
    do_load();
    check_shadow("R8 captured byte at following load");
    chk("R8 channel 0 new byte", 32'(shadow_out[7:0]), 32'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule